// File: doc/BRIEF.md
# Timestamped Interrupt Event Queue

This block turns level-sensitive pending flags from a bank of digital input lines into an ordered record of events. In every clock cycle it looks at the pending flags that are still waiting for service. If any are set, it picks the lowest-numbered one and stores its 1-based line number in a circular buffer, together with the value of a free-running cycle counter. In the following cycle it sends a one-cycle clear pulse back to that line's source. When several lines are pending at once, they are serviced one per cycle in ascending order.

A consumer drains the buffer through a valid/ready port. `evt_valid_o` is high whenever at least one entry is stored. The head entry stays on `evt_line_o`/`evt_ts_o` until a cycle with both `evt_valid_o` and `evt_ready_i` high, and that entry is removed at the end of that cycle. The consumer may hold `evt_ready_i` low for as long as it likes; this back-pressure only lets the buffer fill. The event source is never stalled. Once the buffer is full, a new event is discarded, its line is still acknowledged, and a sticky overflow flag records the loss. A read strobe clears the flag.

The pending sources must drop their flag by the end of the cycle in which they see their clear pulse. During that cycle the block masks the flag itself, so the same line is not serviced twice.

Top module: `irq_event_queue`

## Requirements
- R1: After reset, `evt_empty_o`=1, `evt_valid_o`=0, `evt_line_o`=0, `evt_ts_o`=0, `clr_o`=0 and `ovf_o`=0.
- R2: Among the pending flags that are not being cleared, the one with the lowest bit index is serviced first. Bit i of `pend_i` is reported as line number i+1, so bit 0 is line 1 and bit 23 is line 24.
- R3: At most one line is serviced per clock cycle. A burst of N simultaneous flags produces N entries in N consecutive cycles.
- R4: A 64-bit counter reads 0 in the first cycle after reset and increases by one every clock. Each entry carries the counter value of the cycle in which its line was serviced.
- R5: One cycle after a line is serviced, `clr_o` carries a one-hot pulse on that line's bit for exactly one cycle. During that pulse the bit is ignored by the scan.
- R6: Entries leave in the order they were stored. The buffer holds 1024 entries, and both pointers wrap to zero after the last slot, so operation continues across the wrap.
- R7: `evt_valid_o` equals the inverse of `evt_empty_o`. The head entry holds steady while `evt_ready_i` is low, and one entry is removed per cycle in which valid and ready are both high.
- R8: When the buffer is empty, `evt_line_o` and `evt_ts_o` read 0 and a high `evt_ready_i` removes nothing.
- R9: An event serviced while 1024 entries are stored is discarded and its line still receives its clear pulse. `ovf_o` then rises in the next cycle and stays high.
- R10: A one-cycle `ovf_read_i` strobe clears `ovf_o` in the next cycle, unless an event is discarded in that same cycle.
- R11: A store and a removal may occur in the same cycle, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 24 | Level pending flags, one per input line |
| clr_o | output | 24 | One-hot clear pulse to the serviced line |
| evt_valid_o | output | 1 | Head entry is available |
| evt_ready_i | input | 1 | Consumer accepts the head entry |
| evt_line_o | output | 5 | Head line number, 1 to 24, or 0 when empty |
| evt_ts_o | output | 64 | Head timestamp, 0 when empty |
| evt_empty_o | output | 1 | No entry stored |
| ovf_o | output | 1 | Sticky flag: an event was discarded |
| ovf_read_i | input | 1 | Read strobe that clears the overflow flag |

## Verification
A wrong scan order or a missing mask shows at the ports on the next entry popped and on `clr_o` one cycle after service: lines come out out of order, or a line is reported twice. A pointer or full-detection fault does not appear until the 1024-entry boundary. There it shows as a missing `ovf_o`, as a lost or duplicated entry when the buffer is drained, or as stale data after the pointers wrap. For that reason the buffer is filled completely, overflowed, drained and then used again. A timestamp fault shows on the first entry, because every entry's timestamp can be predicted from the cycle in which its flag was raised.

// File: rtl/ieq_pkg.sv
package ieq_pkg;
  // Default geometry of the event queue
  localparam int unsigned DEF_LINES = 24;
  localparam int unsigned DEF_DEPTH = 1024;
  localparam int unsigned DEF_TS_W  = 64;

  // Width needed to hold line numbers 0..lines (0 = no event)
  function automatic int unsigned line_w(input int unsigned lines);
    return $clog2(lines + 1);
  endfunction
endpackage

// File: rtl/ieq_prio_enc.sv
module ieq_prio_enc #(
  parameter int unsigned LINES = 24,
  parameter int unsigned LW    = 5
) (
  input  logic [LINES-1:0] req_i,
  output logic             found_o,
  output logic [LW-1:0]    idx_o,
  output logic [LINES-1:0] grant_o
);
  // below[i] is set when some request with index < i is present
  logic [LINES:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < LINES; g++) begin : g_chain
    assign below[g+1]  = below[g] | req_i[g];
    assign grant_o[g]  = req_i[g] & ~below[g];
  end

  assign found_o = below[LINES];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (grant_o[i]) idx_o = idx_o | LW'(i + 1);
    end
  end

  always_comb begin
    if (found_o) begin
      // R2
      lowest_pick_chk: assert (((req_i & (grant_o - LINES'(1))) == '0) && ((grant_o & req_i) != '0));
    end
  end
endmodule

// File: rtl/ieq_tstamp.sv
module ieq_tstamp #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_o <= '0;
    else        ts_o <= ts_o + TS_W'(1);
  end

  // R4
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ts_o == $past(ts_o) + TS_W'(1));
endmodule

// File: rtl/ieq_ring.sv
module ieq_ring #(
  parameter int unsigned DW    = 69,
  parameter int unsigned DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          push_acc, pop_acc;
  logic [AW:0]   occ;

  assign empty_o  = (wr_ptr == rd_ptr);
  assign full_o   = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign push_acc = push_i && !full_o;
  assign pop_acc  = pop_i && !empty_o;
  assign occ      = wr_ptr - rd_ptr;
  assign head_o   = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_acc) wr_ptr <= wr_ptr + (AW+1)'(1);
      if (pop_acc)  rd_ptr <= rd_ptr + (AW+1)'(1);
    end
  end

  // R8
  pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> $stable(rd_ptr));

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(DEPTH));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && (wr_ptr[AW-1:0] == '1)) |=> (wr_ptr[AW-1:0] == '0));

  // R11
  both_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(occ));
endmodule

// File: rtl/irq_event_queue.sv
module irq_event_queue
  import ieq_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned TS_W  = DEF_TS_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINES-1:0]           pend_i,
  output logic [LINES-1:0]           clr_o,
  output logic                       evt_valid_o,
  input  logic                       evt_ready_i,
  output logic [line_w(LINES)-1:0]   evt_line_o,
  output logic [TS_W-1:0]            evt_ts_o,
  output logic                       evt_empty_o,
  output logic                       ovf_o,
  input  logic                       ovf_read_i
);
  localparam int unsigned LW = line_w(LINES);
  localparam int unsigned DW = LW + TS_W;

  logic [LINES-1:0] req, grant, clr_q;
  logic             found;
  logic [LW-1:0]    idx;
  logic [TS_W-1:0]  ts_now;
  logic [DW-1:0]    head;
  logic             empty, full, push, drop, pop, ovf_q;

  // Lines already being cleared are hidden from the scan
  assign req = pend_i & ~clr_q;

  ieq_prio_enc #(.LINES(LINES), .LW(LW)) u_enc (
    .req_i   (req),
    .found_o (found),
    .idx_o   (idx),
    .grant_o (grant)
  );

  ieq_tstamp #(.TS_W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .ts_o  (ts_now)
  );

  assign push = found && !full;
  assign drop = found && full;
  assign pop  = evt_ready_i && !empty;

  ieq_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  ({idx, ts_now}),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      clr_q <= found ? grant : '0;
      if (drop)            ovf_q <= 1'b1;
      else if (ovf_read_i) ovf_q <= 1'b0;
    end
  end

  assign clr_o       = clr_q;
  assign ovf_o       = ovf_q;
  assign evt_empty_o = empty;
  assign evt_valid_o = !empty;
  assign evt_line_o  = empty ? '0 : head[DW-1:TS_W];
  assign evt_ts_o    = empty ? '0 : head[TS_W-1:0];

  // R5
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

  // R5
  clr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> ($countones(clr_o) == 1));

  // R9
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found && full) |=> ovf_o);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_read_i) |=> ovf_o);

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(evt_line_o) && $stable(evt_ts_o)));
endmodule

// File: tb/sim_irq_event_queue.sv
module sim_irq_event_queue;
  localparam int PER   = 10;
  localparam int LINES = 24;
  localparam int DEPTH = 1024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] pend = '0;
  logic [LINES-1:0] raise = '0;
  logic [LINES-1:0] clr_o;
  logic             evt_valid_o, evt_empty_o, ovf_o;
  logic             evt_ready_i = 1'b0;
  logic             ovf_read_i = 1'b0;
  logic [4:0]       evt_line_o;
  logic [63:0]      evt_ts_o;
  logic [63:0]      bcnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          exp_line[$];
  logic [63:0] exp_ts[$];
  logic [23:0] exp_clr[$];

  always #(PER/2) clk = ~clk;

  irq_event_queue u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend),
    .clr_o       (clr_o),
    .evt_valid_o (evt_valid_o),
    .evt_ready_i (evt_ready_i),
    .evt_line_o  (evt_line_o),
    .evt_ts_o    (evt_ts_o),
    .evt_empty_o (evt_empty_o),
    .ovf_o       (ovf_o),
    .ovf_read_i  (ovf_read_i)
  );

  // Pending source model: drops a flag at the edge ending its clear pulse
  always @(posedge clk) pend <= (pend & ~clr_o) | raise;

  // Reference cycle count per R4
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0; else bcnt <= bcnt + 64'd1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: raise a set of lines and record what must come out (R2, R3, R4)
  task automatic burst(input logic [23:0] mask, input bit will_drop);
    logic [63:0] c;
    int k = 0;
    @(negedge clk);
    raise = mask;
    c = bcnt;
    for (int i = 0; i < LINES; i++) begin
      if (mask[i]) begin
        if (!will_drop) begin
          exp_line.push_back(i + 1);
          exp_ts.push_back(c + 64'd1 + 64'(k));
        end
        exp_clr.push_back(24'(1) << i);
        k++;
      end
    end
    @(negedge clk);
    raise = '0;
    repeat ($countones(mask) + 3) @(negedge clk);
  endtask

  // Monitor: compares popped entries and clear pulses
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && !done) begin
        if (clr_o != '0) begin
          if (exp_clr.size() == 0) check(1'b0, "R5 unexpected clear", 64'(clr_o), 64'd0);
          else begin
            // R5
            check(clr_o == exp_clr[0], "R5 clear pulse", 64'(clr_o), 64'(exp_clr[0]));
            void'(exp_clr.pop_front());
          end
        end
        // R7
        check(evt_valid_o == !evt_empty_o, "R7 valid vs empty", 64'(evt_valid_o), 64'(!evt_empty_o));
        if (evt_valid_o && evt_ready_i) begin
          if (exp_line.size() == 0) check(1'b0, "R6 unexpected entry", 64'(evt_line_o), 64'd0);
          else begin
            // R2 R6
            check(evt_line_o == 5'(exp_line[0]), "R2/R6 line", 64'(evt_line_o), 64'(exp_line[0]));
            // R4
            check(evt_ts_o == exp_ts[0], "R4 timestamp", evt_ts_o, exp_ts[0]);
            void'(exp_line.pop_front());
            void'(exp_ts.pop_front());
          end
        end
      end
    end
  end

  task automatic drain();
    for (int n = 0; n < 3000 && exp_line.size() != 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0]  hl;
    logic [63:0] ht;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1
    check(evt_empty_o == 1'b1 && evt_valid_o == 1'b0, "R1 empty after reset", 64'(evt_empty_o), 64'd1);
    check(evt_line_o == '0 && evt_ts_o == '0, "R1 head zero", evt_ts_o, 64'd0);
    check(clr_o == '0 && ovf_o == 1'b0, "R1 clear/ovf idle", 64'(clr_o), 64'd0);

    // R8: pop on empty removes nothing
    @(negedge clk);
    evt_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(evt_line_o == '0 && evt_ts_o == '0 && !evt_valid_o, "R8 empty head", 64'(evt_line_o), 64'd0);

    // R2 R3: orderings, single lines at both ends
    burst(24'h000001, 1'b0);
    burst(24'h800000, 1'b0);
    burst(24'h020208, 1'b0);
    burst(24'h81_00_81, 1'b0);
    // R11: all lines with consumer ready, store and remove overlap
    burst(24'hFFFFFF, 1'b0);
    drain();
    check(exp_line.size() == 0, "R11 all entries out", 64'(exp_line.size()), 64'd0);

    // R7: back-pressure holds head
    @(negedge clk);
    evt_ready_i = 1'b0;
    burst(24'h000410, 1'b0);
    #2;
    hl = evt_line_o; ht = evt_ts_o;
    repeat (5) @(negedge clk);
    #2;
    check(evt_line_o == hl && evt_ts_o == ht, "R7 head held", 64'(evt_line_o), 64'(hl));
    check(evt_line_o == 5'd5, "R7 head line", 64'(evt_line_o), 64'd5);

    // R6 R9: fill to 1024 (2 already stored)
    for (int b = 0; b < 42; b++) burst(24'hFFFFFF, 1'b0);
    for (int j = 0; j < 14; j++) burst(24'(1) << (j % 24), 1'b0);
    check(ovf_o == 1'b0, "R9 no overflow at exactly full", 64'(ovf_o), 64'd0);
    burst(24'h000010, 1'b1);
    #2;
    check(ovf_o == 1'b1, "R9 overflow set", 64'(ovf_o), 64'd1);
    check(pend == '0, "R9 dropped line cleared", 64'(pend), 64'd0);
    repeat (4) @(negedge clk);
    #2;
    check(ovf_o == 1'b1, "R9 overflow sticky", 64'(ovf_o), 64'd1);

    // R10
    @(negedge clk);
    ovf_read_i = 1'b1;
    @(negedge clk);
    ovf_read_i = 1'b0;
    #2;
    check(ovf_o == 1'b0, "R10 overflow cleared by read", 64'(ovf_o), 64'd0);

    // R6: drain 1024 in order, then run across the wrapped pointers
    @(negedge clk);
    evt_ready_i = 1'b1;
    drain();
    check(evt_empty_o == 1'b1, "R6 empty after drain", 64'(evt_empty_o), 64'd1);
    burst(24'hFFFFFF, 1'b0);
    burst(24'h400002, 1'b0);
    drain();
    #2;
    check(evt_empty_o && evt_line_o == '0, "R8 empty after wrap", 64'(evt_line_o), 64'd0);
    check(exp_clr.size() == 0, "R5 all clears seen", 64'(exp_clr.size()), 64'd0);
    check(exp_line.size() == 0, "R6 all entries seen", 64'(exp_line.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule